// File: doc/BRIEF.md
# Interrupt Pending and Delivery Priority Unit

This unit records pending interrupts for seven interrupt classes and picks the single class that should be delivered to the processor. Each class owns a 64-bit pending vector and a one-bit summary flag. Synchronous post and clear requests name a class and a bit index. The current privilege mode and interrupt-enable state decide which class wins, and the winner is given as a 3-bit cause code. For the software-interrupt class the unit also encodes a 4-bit level from that class's vector.

Class numbers and cause codes are the same: 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 software interrupt, 6 resumable error, 7 nothing to deliver. A combinational read port returns any class's vector for inspection.

Top module: `irq_priority_unit`

## Requirements
- R1: A post with class 0..6 and index 0..63 sets that bit of that class's vector and sets the class's summary flag. Both changes are visible in the cycle after the clock edge.
- R2: A clear resets the addressed bit. The class's summary flag drops only when the vector is entirely zero after the clear. Otherwise the flag stays set.
- R3: `clear_all` zeroes every vector and every summary flag, and it overrides any post or clear in the same cycle. `any_pending` is high exactly when at least one summary flag is set.
- R4: While `hyp_mode` is high, a class is delivered only if `int_enable` is high. Class 1 is delivered before class 2, and no other class is ever delivered in this mode (cause 7).
- R5: While `hyp_mode` is low, classes 0, 1 and 2 are delivered in that order of priority, whatever the value of `int_enable`.
- R6: While `hyp_mode` is low and `int_enable` is high, classes 3, 4, 5 and 6 follow classes 0..2 in that order. While `int_enable` is low they are never delivered.
- R7: `soft_level` is 14 when bit 16 or bit 0 of the class-5 vector is set. Otherwise it is the index of the highest set bit among bits 15..1, or 0 when none of those is set. Class 5 is still delivered when only bits above 16 are set.
- R8: When a post and a clear address the same class and index in one cycle, the post wins. A post or clear with class 7 changes nothing.
- R9: `rd_vector` shows the vector of the class on `rd_class` in the same cycle. `rd_class` 7 reads as zero.
- R10: After reset all vectors and flags are zero, `any_pending` is low and `cause` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_all | input | 1 | Zero all vectors and flags at the next edge |
| post_valid | input | 1 | Post request strobe |
| post_class | input | 3 | Class addressed by the post |
| post_index | input | 6 | Bit index set by the post |
| clr_valid | input | 1 | Clear request strobe |
| clr_class | input | 3 | Class addressed by the clear |
| clr_index | input | 6 | Bit index reset by the clear |
| hyp_mode | input | 1 | Processor is in hyperprivileged mode |
| int_enable | input | 1 | Interrupt-enable state bit |
| rd_class | input | 3 | Class selected for readback |
| rd_vector | output | 64 | Pending vector of the selected class |
| class_pending | output | 7 | Summary flag of each class |
| any_pending | output | 1 | Some class has a pending interrupt |
| cause | output | 3 | Class to deliver, 7 when none |
| soft_level | output | 4 | Level encoded from the software-interrupt vector |

## Verification
The assertions take every input as a clean synchronous level, sampled at the rising edge, with no X on the strobes or the class fields. They also assume that `hyp_mode` and `int_enable` may change in any cycle, because cause selection is purely combinational on them. The stimulus changes all inputs only on the falling edge and returns the strobes to zero after each request. It also uses class 7 on purpose, to check the ignore rule against the out-of-range property.

// File: rtl/irq_pu_pkg.sv
package irq_pu_pkg;
  localparam int NUM_CLASSES = 7;
  localparam int VEC_W       = 64;
  localparam int CLS_W       = 3;
  localparam int IDX_W       = 6;
  localparam int LVL_W       = 4;

  // soft-interrupt level encoding constants
  localparam int SOFT_ALIAS_BIT = 16;
  localparam int SOFT_TOP_BIT   = 15;
  localparam int SOFT_FORCE_LVL = 14;

  typedef enum logic [CLS_W-1:0] {
    CLS_TLZ       = 3'd0,
    CLS_HTICK     = 3'd1,
    CLS_IVEC      = 3'd2,
    CLS_CPU_MONDO = 3'd3,
    CLS_DEV_MONDO = 3'd4,
    CLS_SOFT      = 3'd5,
    CLS_RES_ERR   = 3'd6,
    CLS_NONE      = 3'd7
  } irq_cls_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N  = irq_pu_pkg::NUM_CLASSES,
  parameter int W  = irq_pu_pkg::VEC_W,
  parameter int CW = irq_pu_pkg::CLS_W,
  parameter int IW = irq_pu_pkg::IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_all,
  input  logic                 post_valid,
  input  logic [CW-1:0]        post_class,
  input  logic [IW-1:0]        post_index,
  input  logic                 clr_valid,
  input  logic [CW-1:0]        clr_class,
  input  logic [IW-1:0]        clr_index,
  output logic [N-1:0][W-1:0]  vec_q,
  output logic [N-1:0]         flag_q,
  output logic [N-1:0]         post_hit,
  output logic [N-1:0]         clr_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cls
    localparam logic [CW-1:0] MY_CLS = CW'(g);
    logic [W-1:0] set_m, clr_m, nxt;

    assign post_hit[g] = post_valid && (post_class == MY_CLS);
    assign clr_hit[g]  = clr_valid  && (clr_class  == MY_CLS);

    always_comb begin
      set_m = '0;
      clr_m = '0;
      if (post_hit[g]) set_m[post_index] = 1'b1;
      if (clr_hit[g])  clr_m[clr_index]  = 1'b1;
      // set applied after clear: a colliding post wins
      nxt = (vec_q[g] & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g]  <= '0;
        flag_q[g] <= 1'b0;
      end else if (clear_all) begin
        vec_q[g]  <= '0;
        flag_q[g] <= 1'b0;
      end else begin
        vec_q[g] <= nxt;
        if (post_hit[g])
          flag_q[g] <= 1'b1;
        else if (clr_hit[g] && (nxt == '0))
          flag_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level #(
  parameter int W  = irq_pu_pkg::VEC_W,
  parameter int LW = irq_pu_pkg::LVL_W
) (
  input  logic [W-1:0]  soft_vec,
  output logic [LW-1:0] level
);
  import irq_pu_pkg::*;

  function automatic logic [LW-1:0] level_of(input logic [W-1:0] v);
    logic [LW-1:0] l;
    l = '0;
    if (v[SOFT_ALIAS_BIT] || v[0]) begin
      l = LW'(SOFT_FORCE_LVL);
    end else begin
      for (int b = 1; b <= SOFT_TOP_BIT; b++)
        if (v[b]) l = LW'(b);
    end
    return l;
  endfunction

  assign level = level_of(soft_vec);
endmodule

// File: rtl/irq_deliver_arb.sv
module irq_deliver_arb #(
  parameter int N  = irq_pu_pkg::NUM_CLASSES,
  parameter int CW = irq_pu_pkg::CLS_W
) (
  input  logic [N-1:0]  pend,
  input  logic          hyp_mode,
  input  logic          int_enable,
  output logic [CW-1:0] cause
);
  import irq_pu_pkg::*;

  always_comb begin
    cause = CLS_NONE;
    if (hyp_mode) begin
      if (int_enable) begin
        if (pend[CLS_HTICK])     cause = CLS_HTICK;
        else if (pend[CLS_IVEC]) cause = CLS_IVEC;
      end
    end else begin
      if (pend[CLS_TLZ])         cause = CLS_TLZ;
      else if (pend[CLS_HTICK])  cause = CLS_HTICK;
      else if (pend[CLS_IVEC])   cause = CLS_IVEC;
      else if (int_enable) begin
        if (pend[CLS_CPU_MONDO])      cause = CLS_CPU_MONDO;
        else if (pend[CLS_DEV_MONDO]) cause = CLS_DEV_MONDO;
        else if (pend[CLS_SOFT])      cause = CLS_SOFT;
        else if (pend[CLS_RES_ERR])   cause = CLS_RES_ERR;
      end
    end
  end
endmodule

// File: rtl/irq_priority_unit.sv
module irq_priority_unit #(
  parameter int N  = irq_pu_pkg::NUM_CLASSES,
  parameter int W  = irq_pu_pkg::VEC_W,
  parameter int CW = irq_pu_pkg::CLS_W,
  parameter int IW = irq_pu_pkg::IDX_W,
  parameter int LW = irq_pu_pkg::LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_all,
  input  logic          post_valid,
  input  logic [CW-1:0] post_class,
  input  logic [IW-1:0] post_index,
  input  logic          clr_valid,
  input  logic [CW-1:0] clr_class,
  input  logic [IW-1:0] clr_index,
  input  logic          hyp_mode,
  input  logic          int_enable,
  input  logic [CW-1:0] rd_class,
  output logic [W-1:0]  rd_vector,
  output logic [N-1:0]  class_pending,
  output logic          any_pending,
  output logic [CW-1:0] cause,
  output logic [LW-1:0] soft_level
);
  import irq_pu_pkg::*;
  localparam int SLOTS = 1 << CW;

  logic [N-1:0][W-1:0]     vec_q;
  logic [N-1:0]            post_hit;
  logic [N-1:0]            clr_hit;
  logic [SLOTS-1:0][W-1:0] rd_tab;

  irq_pend_bank #(.N(N), .W(W), .CW(CW), .IW(IW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (clear_all),
    .post_valid (post_valid),
    .post_class (post_class),
    .post_index (post_index),
    .clr_valid  (clr_valid),
    .clr_class  (clr_class),
    .clr_index  (clr_index),
    .vec_q      (vec_q),
    .flag_q     (class_pending),
    .post_hit   (post_hit),
    .clr_hit    (clr_hit)
  );

  irq_deliver_arb #(.N(N), .CW(CW)) u_arb (
    .pend       (class_pending),
    .hyp_mode   (hyp_mode),
    .int_enable (int_enable),
    .cause      (cause)
  );

  irq_soft_level #(.W(W), .LW(LW)) u_lvl (
    .soft_vec (vec_q[CLS_SOFT]),
    .level    (soft_level)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    if (s < N) begin : g_live
      assign rd_tab[s] = vec_q[s];
    end else begin : g_pad
      assign rd_tab[s] = '0;
    end
  end

  assign rd_vector   = rd_tab[rd_class];
  assign any_pending = |class_pending;
endmodule

// File: rtl/irq_pu_chk.sv
module irq_pu_chk #(
  parameter int N  = irq_pu_pkg::NUM_CLASSES,
  parameter int W  = irq_pu_pkg::VEC_W,
  parameter int CW = irq_pu_pkg::CLS_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clear_all,
  input logic                post_valid,
  input logic [CW-1:0]       post_class,
  input logic                clr_valid,
  input logic [CW-1:0]       clr_class,
  input logic                hyp_mode,
  input logic                int_enable,
  input logic [N-1:0]        class_pending,
  input logic                any_pending,
  input logic [CW-1:0]       cause,
  input logic [N-1:0]        post_hit,
  input logic [N-1:0][W-1:0] vec_q
);
  localparam int PADW = 1 << CW;
  localparam logic [CW-1:0] NONE = '1;
  logic [PADW-1:0] pend_pad;
  assign pend_pad = PADW'(class_pending);

  p_post_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|post_hit && !clear_all) |=> ((class_pending & $past(post_hit)) == $past(post_hit)));

  for (genvar k = 0; k < N; k++) begin : g_flag
    p_flag_tracks_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      class_pending[k] == (vec_q[k] != '0));
  end

  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (class_pending == '0) && !any_pending);

  p_any_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_pending == (class_pending != '0));

  p_hyp_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hyp_mode && !int_enable) |-> cause == NONE);

  p_hyp_classes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_mode |-> (cause == 3'd1 || cause == 3'd2 || cause == NONE));

  p_masked_classes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enable |-> (cause <= 3'd2 || cause == NONE));

  p_cause_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != NONE) |-> pend_pad[cause]);

  p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_class == NONE && !(clr_valid && clr_class != NONE) && !clear_all)
      |=> $stable(class_pending) && $stable(vec_q));
endmodule

bind irq_priority_unit irq_pu_chk #(.N(N), .W(W), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear_all     (clear_all),
  .post_valid    (post_valid),
  .post_class    (post_class),
  .clr_valid     (clr_valid),
  .clr_class     (clr_class),
  .hyp_mode      (hyp_mode),
  .int_enable    (int_enable),
  .class_pending (class_pending),
  .any_pending   (any_pending),
  .cause         (cause),
  .post_hit      (post_hit),
  .vec_q         (vec_q)
);

// File: tb/irq_priority_unit_tb.sv
module irq_priority_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_all = 0, post_valid = 0, clr_valid = 0, hyp_mode = 0, int_enable = 0;
  logic [2:0] post_class = 0, clr_class = 0, rd_class = 0;
  logic [5:0] post_index = 0, clr_index = 0;
  logic [63:0] rd_vector;
  logic [6:0]  class_pending;
  logic        any_pending;
  logic [2:0]  cause;
  logic [3:0]  soft_level;

  int checks = 0;
  int fails  = 0;
  logic [63:0] m [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_priority_unit u_dut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .post_valid(post_valid), .post_class(post_class), .post_index(post_index),
    .clr_valid(clr_valid), .clr_class(clr_class), .clr_index(clr_index),
    .hyp_mode(hyp_mode), .int_enable(int_enable), .rd_class(rd_class),
    .rd_vector(rd_vector), .class_pending(class_pending), .any_pending(any_pending),
    .cause(cause), .soft_level(soft_level)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected cause: walk a priority list built from the mode rules
  function automatic logic [2:0] exp_cause(input logic hyp, input logic ie);
    int order [7];
    int cnt = 0;
    if (hyp) begin
      if (ie) begin order[0] = 1; order[1] = 2; cnt = 2; end
    end else begin
      order[0] = 0; order[1] = 1; order[2] = 2; cnt = 3;
      if (ie) begin order[3] = 3; order[4] = 4; order[5] = 5; order[6] = 6; cnt = 7; end
    end
    for (int i = 0; i < cnt; i++)
      if (m[order[i]] != 0) return 3'(order[i]);
    return 3'd7;
  endfunction

  function automatic logic [3:0] exp_level(input logic [63:0] v);
    if (v[16] | v[0]) return 4'd14;
    for (int b = 15; b >= 1; b--) if (v[b]) return 4'(b);
    return 4'd0;
  endfunction

  // one request cycle, model updated by the rules of R1, R2, R3, R8
  task automatic req(input logic pv, input int pc, input int pi,
                     input logic cv, input int cc, input int ci, input logic ca);
    @(negedge clk);
    post_valid = pv; post_class = 3'(pc); post_index = 6'(pi);
    clr_valid = cv;  clr_class = 3'(cc);  clr_index = 6'(ci);
    clear_all = ca;
    @(negedge clk);
    post_valid = 0; clr_valid = 0; clear_all = 0;
    if (ca) begin
      for (int c = 0; c < 7; c++) m[c] = '0;
    end else begin
      if (cv && cc < 7) m[cc][ci] = 1'b0;
      if (pv && pc < 7) m[pc][pi] = 1'b1;
    end
    #1;
  endtask

  task automatic check_state(input string tag);
    logic [6:0] f;
    for (int c = 0; c < 7; c++) begin
      rd_class = 3'(c); #1;
      chk({tag, " R9 readback"}, rd_vector, m[c]);
      f[c] = (m[c] != 0);
    end
    chk({tag, " R2 flags"}, 64'(class_pending), 64'(f));
    chk({tag, " R3 any_pending"}, 64'(any_pending), 64'(f != 0));
    chk({tag, " R7 level"}, 64'(soft_level), 64'(exp_level(m[5])));
    chk({tag, " cause"}, 64'(cause), 64'(exp_cause(hyp_mode, int_enable)));
  endtask

  task automatic set_mode(input logic h, input logic ie);
    @(negedge clk); hyp_mode = h; int_enable = ie; #1;
  endtask

  task automatic t_reset;
    for (int c = 0; c < 7; c++) m[c] = '0;
    chk("R10 reset cause", 64'(cause), 64'd7);
    chk("R10 reset any_pending", 64'(any_pending), 64'd0);
    check_state("R10");
  endtask

  task automatic t_post_clear;
    set_mode(0, 1);
    req(1, 3, 5, 0, 0, 0, 0);
    chk("R1 flag set", 64'(class_pending), 64'h08);
    req(1, 3, 63, 0, 0, 0, 0);
    check_state("R1");
    req(0, 0, 0, 1, 3, 5, 0);
    chk("R2 flag stays", 64'(class_pending[3]), 64'd1);
    req(0, 0, 0, 1, 3, 63, 0);
    chk("R2 flag drops", 64'(class_pending[3]), 64'd0);
    check_state("R2");
  endtask

  task automatic t_clear_all;
    req(1, 0, 1, 0, 0, 0, 0);
    req(1, 6, 40, 0, 0, 0, 0);
    req(1, 2, 2, 1, 6, 40, 1);
    chk("R3 clear_all wins", 64'(class_pending), 64'd0);
    check_state("R3");
  endtask

  task automatic t_hyp;
    req(1, 0, 3, 0, 0, 0, 0);
    req(1, 3, 3, 0, 0, 0, 0);
    req(1, 5, 3, 0, 0, 0, 0);
    req(1, 6, 3, 0, 0, 0, 0);
    set_mode(1, 1);
    chk("R4 others blocked", 64'(cause), 64'd7);
    req(1, 2, 9, 0, 0, 0, 0);
    chk("R4 vector delivered", 64'(cause), 64'd2);
    req(1, 1, 9, 0, 0, 0, 0);
    chk("R4 tick first", 64'(cause), 64'd1);
    set_mode(1, 0);
    chk("R4 enable gate", 64'(cause), 64'd7);
    check_state("R4");
  endtask

  task automatic t_nonhyp;
    req(1, 4, 0, 0, 0, 0, 0);
    set_mode(0, 0);
    chk("R5 tlz first", 64'(cause), 64'd0);
    req(0, 0, 0, 1, 0, 3, 0);
    chk("R5 tick next", 64'(cause), 64'd1);
    req(0, 0, 0, 1, 1, 9, 0);
    chk("R5 vector next", 64'(cause), 64'd2);
    req(0, 0, 0, 1, 2, 9, 0);
    chk("R6 masked", 64'(cause), 64'd7);
    set_mode(0, 1);
    chk("R6 cpu mondo", 64'(cause), 64'd3);
    req(0, 0, 0, 1, 3, 3, 0);
    chk("R6 dev mondo", 64'(cause), 64'd4);
    req(0, 0, 0, 1, 4, 0, 0);
    chk("R6 soft", 64'(cause), 64'd5);
    req(0, 0, 0, 1, 5, 3, 0);
    chk("R6 resumable error", 64'(cause), 64'd6);
    check_state("R6");
    req(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_level;
    set_mode(0, 1);
    req(1, 5, 9, 0, 0, 0, 0);
    req(1, 5, 3, 0, 0, 0, 0);
    chk("R7 highest bit", 64'(soft_level), 64'd9);
    req(1, 5, 16, 0, 0, 0, 0);
    chk("R7 bit16 forces 14", 64'(soft_level), 64'd14);
    req(0, 0, 0, 0, 0, 0, 1);
    req(1, 5, 0, 0, 0, 0, 0);
    chk("R7 bit0 forces 14", 64'(soft_level), 64'd14);
    req(1, 5, 15, 1, 5, 0, 0);
    chk("R7 bit15", 64'(soft_level), 64'd15);
    req(1, 5, 40, 1, 5, 15, 0);
    chk("R7 high-only level", 64'(soft_level), 64'd0);
    chk("R7 high-only delivered", 64'(cause), 64'd5);
    check_state("R7");
    req(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_collision;
    req(1, 4, 7, 1, 4, 7, 0);
    chk("R8 post wins", 64'(class_pending[4]), 64'd1);
    req(1, 7, 12, 0, 0, 0, 0);
    chk("R8 class7 post ignored", 64'(class_pending), 64'h10);
    req(0, 0, 0, 1, 7, 7, 0);
    chk("R8 class7 clear ignored", 64'(class_pending), 64'h10);
    check_state("R8");
  endtask

  task automatic t_read;
    rd_class = 3'd7; #1;
    chk("R9 class7 reads zero", rd_vector, 64'd0);
    rd_class = 3'd4; #1;
    chk("R9 same-cycle read", rd_vector, 64'h80);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_post_clear();
    t_clear_all();
    t_hyp();
    t_nonhyp();
    t_level();
    t_collision();
    t_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule